// File: doc/BRIEF.md
# PWM Fault Protection Controller

This block sits between the waveform generators of a multi-channel PWM timer and the output pins. It watches a group of event fault inputs and a halt request from the debug system. When a fault it is set to respond to is present, it overrides every PWM output with a programmable idle level. The override takes effect in the same cycle as the fault, with no register in the path. The same fault-active signal also tells the timer to enter its own fault state.

Once the fault source has gone, the outputs come back in one of two ways. In cycle-by-cycle mode they return at the first timer update strobe that arrives after the fault has cleared. In latched mode they stay in the idle level until software clears the sticky fault flag.

Software programs the block through a small write-only register port. Address 0 is control, address 1 is the event mask, address 2 is the idle level, and address 3 clears the flag. Once the lock bit is set, the event mask is frozen.

Top module: `pwm_fault_guard`

## Requirements
- R1: After a synchronous active-low reset, all configuration is zero, `fault_flag_o` and `fault_active_o` are 0, and `pwm_o` equals `pwm_i`.
- R2: With the enable bit (address 0, bit 0) set, an event input whose mask bit (address 1, bit n for input n) is 1 raises `fault_active_o` combinationally in the same cycle.
- R3: An event input whose mask bit is 0 has no effect on `fault_active_o`, `fault_flag_o` or `pwm_o`.
- R4: With enable set, `brk_req_i` is a fault source by default. When the break-ignore bit (address 0, bit 2) is 1, `brk_req_i` has no effect.
- R5: With the enable bit at 0, no source raises a fault or sets the flag.
- R6: In cycle-by-cycle mode (address 0, bit 1 = 0), `fault_active_o` stays high after the fault ends. It drops in the cycle after the first `update_i` pulse that is sampled while no fault is present.
- R7: In latched mode (address 0, bit 1 = 1), `fault_active_o` stays high after the fault ends, including across update strobes, until the flag is cleared.
- R8: `fault_flag_o` is set in the cycle after any fault. It is cleared by writing 1 to bit 0 of address 3. If a fault is present in the cycle of that write, the flag stays set.
- R9: The lock bit (address 0, bit 3) can only be set, and only reset clears it. While it is 1, writes to address 1 leave the mask unchanged.
- R10: While `fault_active_o` is high, `pwm_o` equals the idle level written at address 2 (channel n from bit n). The idle level is all-zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| update_i | input | 1 | Timer update strobe, one cycle wide |
| brk_req_i | input | 1 | Halt request from the debug system |
| evt_fault_i | input | NEVT | Event fault inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | DW | Register write data |
| pwm_i | input | NCH | Waveforms from the timer |
| pwm_o | output | NCH | Gated waveforms to the pins |
| fault_active_o | output | 1 | Fault state, to the output stage and the timer |
| fault_flag_o | output | 1 | Sticky fault flag |

## Verification
A wrong recovery state shows up at `fault_active_o` and `pwm_o`. If the hold is lost, the outputs resume early, one cycle after a fault ends without an update strobe. If the hold is stuck, the outputs stay at the idle level past the strobe or the flag clear. A wrong flag shows in the cycle after a clear write that is made while a fault is present. A mask that accepted a write while locked shows the first time the old and the new masked inputs are pulsed. The bench predicts every output on every cycle, so each of these faults is caught within a cycle of the stimulus that exposes it.

// File: rtl/pfg_pkg.sv
// Package: shared register addresses and the control register layout for
// the PWM fault protection controller. Assumes a 2-bit register address.
package pfg_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] A_IDLE = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd3;

    localparam int CB_EN      = 0;
    localparam int CB_LATCHED = 1;
    localparam int CB_BRK_IGN = 2;
    localparam int CB_LOCK    = 3;

    typedef struct packed {
        logic lock;
        logic brk_ign;
        logic latched;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/pfg_regs.sv
// Module: configuration registers. Holds control, event mask and idle level.
// Decodes the flag-clear write into a one-cycle pulse.
// Assumes NEVT <= DW and NCH <= DW. Lock is set-only and reset clears it.
module pfg_regs
    import pfg_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NEVT = 4,
    parameter int DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    output ctrl_t             ctrl_o,
    output logic [NEVT-1:0]   mask_o,
    output logic [NCH-1:0]    idle_o,
    output logic              flag_clr_o
);
    ctrl_t           ctrl_q;
    logic [NEVT-1:0] mask_q;
    logic [NCH-1:0]  idle_q;

    // Purpose: register writes; the mask is frozen while the lock is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            idle_q <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL: begin
                    ctrl_q.en      <= wr_data_i[CB_EN];
                    ctrl_q.latched <= wr_data_i[CB_LATCHED];
                    ctrl_q.brk_ign <= wr_data_i[CB_BRK_IGN];
                    ctrl_q.lock    <= ctrl_q.lock | wr_data_i[CB_LOCK];
                end
                A_MASK: if (!ctrl_q.lock) mask_q <= wr_data_i[NEVT-1:0];
                A_IDLE: idle_q <= wr_data_i[NCH-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: one-cycle pulse for a write of 1 to the flag-clear bit.
    always_comb flag_clr_o = wr_en_i && (wr_addr_i == A_FLAG) && wr_data_i[0];

    assign ctrl_o = ctrl_q;
    assign mask_o = mask_q;
    assign idle_o = idle_q;
endmodule

// File: rtl/pfg_detect.sv
// Module: combinational fault detection. Each event input is qualified by
// its mask bit, the break request by the break-ignore bit, and the result
// by the global enable. Has no state, so the result is valid in the same cycle.
module pfg_detect
    import pfg_pkg::*;
#(
    parameter int NEVT = 4
) (
    input  ctrl_t           ctrl_i,
    input  logic [NEVT-1:0] mask_i,
    input  logic [NEVT-1:0] evt_fault_i,
    input  logic            brk_req_i,
    output logic            fault_now_o
);
    logic [NEVT-1:0] evt_hit;

    // Purpose: per-source qualification of the event inputs by the mask.
    for (genvar e = 0; e < NEVT; e++) begin : g_evt
        assign evt_hit[e] = evt_fault_i[e] & mask_i[e];
    end

    // Purpose: combine the sources under the enable and the break-ignore bit.
    always_comb begin
        fault_now_o = ctrl_i.en & ((|evt_hit) | (brk_req_i & ~ctrl_i.brk_ign));
    end
endmodule

// File: rtl/pfg_recover.sv
// Module: sticky fault flag and the recovery state. Cycle-by-cycle mode
// keeps the hold until an update strobe arrives while no fault is present.
// Latched mode keeps the fault state until software clears the flag.
// A fault in the same cycle as a clear write wins over the clear.
module pfg_recover (
    input  logic clk,
    input  logic rst_n,
    input  logic latched_i,
    input  logic fault_now_i,
    input  logic update_i,
    input  logic flag_clr_i,
    output logic flag_o,
    output logic hold_o,
    output logic fault_active_o
);
    logic flag_q;
    logic hold_q;

    // Purpose: the flag is set by any fault and cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)           flag_q <= 1'b0;
        else if (fault_now_i) flag_q <= 1'b1;
        else if (flag_clr_i)  flag_q <= 1'b0;
    end

    // Purpose: the cycle-by-cycle hold is released by a fault-free update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           hold_q <= 1'b0;
        else if (fault_now_i) hold_q <= 1'b1;
        else if (update_i)    hold_q <= 1'b0;
    end

    // Purpose: fault state is the live fault or the stored state of the selected mode.
    always_comb fault_active_o = fault_now_i | (latched_i ? flag_q : hold_q);

    assign flag_o = flag_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/pfg_gate.sv
// Module: per-channel output override. While in the fault state each
// channel drives its idle bit; otherwise the timer waveform passes through.
module pfg_gate #(
    parameter int NCH = 8
) (
    input  logic           active_i,
    input  logic [NCH-1:0] idle_i,
    input  logic [NCH-1:0] pwm_i,
    output logic [NCH-1:0] pwm_o
);
    // Purpose: one 2:1 selector for each channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign pwm_o[c] = active_i ? idle_i[c] : pwm_i[c];
    end
endmodule

// File: rtl/pwm_fault_guard.sv
// Module: top of the PWM fault protection controller. Connects the
// registers, detection, recovery and output gating.
// Assumes update_i comes from the same clock domain as the block.
module pwm_fault_guard
    import pfg_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NEVT = 4,
    parameter int DW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update_i,
    input  logic              brk_req_i,
    input  logic [NEVT-1:0]   evt_fault_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [NCH-1:0]    pwm_i,
    output logic [NCH-1:0]    pwm_o,
    output logic              fault_active_o,
    output logic              fault_flag_o
);
    ctrl_t           ctrl;
    logic [NEVT-1:0] mask_q;
    logic [NCH-1:0]  idle_q;
    logic            flag_clr;
    logic            fault_now;
    logic            hold_q;

    pfg_regs #(.NCH(NCH), .NEVT(NEVT), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ctrl_o(ctrl), .mask_o(mask_q),
        .idle_o(idle_q), .flag_clr_o(flag_clr)
    );

    pfg_detect #(.NEVT(NEVT)) u_detect (
        .ctrl_i(ctrl), .mask_i(mask_q), .evt_fault_i(evt_fault_i),
        .brk_req_i(brk_req_i), .fault_now_o(fault_now)
    );

    pfg_recover u_recover (
        .clk(clk), .rst_n(rst_n), .latched_i(ctrl.latched),
        .fault_now_i(fault_now), .update_i(update_i), .flag_clr_i(flag_clr),
        .flag_o(fault_flag_o), .hold_o(hold_q), .fault_active_o(fault_active_o)
    );

    pfg_gate #(.NCH(NCH)) u_gate (
        .active_i(fault_active_o), .idle_i(idle_q), .pwm_i(pwm_i), .pwm_o(pwm_o)
    );
endmodule

// File: rtl/pfg_checker.sv
// Module: assertion checker for pwm_fault_guard, attached with bind.
module pfg_checker #(
    parameter int NCH  = 8,
    parameter int NEVT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en_i,
    input logic [1:0]      wr_addr_i,
    input logic            update_i,
    input logic            latched,
    input logic            lock,
    input logic [NEVT-1:0] mask_q,
    input logic [NCH-1:0]  idle_q,
    input logic            fault_now,
    input logic            flag_clr,
    input logic            fault_active_o,
    input logic            fault_flag_o,
    input logic [NCH-1:0]  pwm_o
);
    // R2: a detected fault gates the outputs in the same cycle
    a_r2_fault_gates_now: assert property (@(posedge clk) disable iff (!rst_n)
        fault_now |-> fault_active_o);

    // R10: in the fault state the outputs carry the idle level
    a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        fault_active_o |-> (pwm_o == idle_q));

    // R8: a fault sets the flag in the next cycle
    a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fault_now |=> fault_flag_o);

    // R8: without a clear write the flag stays set
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag_o && !flag_clr) |=> fault_flag_o);

    // R9: mask writes under lock leave the mask unchanged
    a_r9_lock_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en_i && wr_addr_i == 2'd1) |=> $stable(mask_q));

    // R9: the lock cannot be cleared
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R6: without an update strobe the cycle-by-cycle fault state persists
    a_r6_cbc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched && fault_active_o && !update_i && !wr_en_i) |=> fault_active_o);

    // R7: without a register write the latched fault state persists
    a_r7_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && fault_active_o && !wr_en_i) |=> fault_active_o);
endmodule

bind pwm_fault_guard pfg_checker #(.NCH(NCH), .NEVT(NEVT)) u_pfg_checker (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .update_i(update_i), .latched(ctrl.latched), .lock(ctrl.lock),
    .mask_q(mask_q), .idle_q(idle_q), .fault_now(fault_now),
    .flag_clr(flag_clr), .fault_active_o(fault_active_o),
    .fault_flag_o(fault_flag_o), .pwm_o(pwm_o)
);

// File: tb/test_pwm_fault_guard.sv
// Bench: a behavioural reference model predicts every output, and the
// outputs are compared after each input change, once per clock.
module test_pwm_fault_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int NEVT = 4;
    localparam int DW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            update_i = 1'b0;
    logic            brk_req_i = 1'b0;
    logic [NEVT-1:0] evt_fault_i = '0;
    logic            wr_en_i = 1'b0;
    logic [1:0]      wr_addr_i = '0;
    logic [DW-1:0]   wr_data_i = '0;
    logic [NCH-1:0]  pwm_i = '0;
    logic [NCH-1:0]  pwm_o;
    logic            fault_active_o;
    logic            fault_flag_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    bit            m_en, m_lat, m_bign, m_lock, m_flag, m_hold;
    bit [NEVT-1:0] m_mask;
    bit [NCH-1:0]  m_idle;

    pwm_fault_guard #(.NCH(NCH), .NEVT(NEVT), .DW(DW)) i_pwm_fault_guard (
        .clk(clk), .rst_n(rst_n), .update_i(update_i), .brk_req_i(brk_req_i),
        .evt_fault_i(evt_fault_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .pwm_i(pwm_i), .pwm_o(pwm_o),
        .fault_active_o(fault_active_o), .fault_flag_o(fault_flag_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit model_fault();
        return m_en && ((brk_req_i && !m_bign) || ((evt_fault_i & m_mask) != 0));
    endfunction

    function automatic bit model_active();
        return model_fault() || (m_lat ? m_flag : m_hold);
    endfunction

    // Reference model: register writes, flag and recovery state
    always @(posedge clk) begin
        bit f;
        f = model_fault();
        if (!rst_n) begin
            m_en <= 0; m_lat <= 0; m_bign <= 0; m_lock <= 0;
            m_flag <= 0; m_hold <= 0; m_mask <= '0; m_idle <= '0;
        end else begin
            if (wr_en_i && wr_addr_i == 2'd0) begin
                m_en   <= wr_data_i[0];
                m_lat  <= wr_data_i[1];
                m_bign <= wr_data_i[2];
                m_lock <= m_lock || wr_data_i[3];
            end
            if (wr_en_i && wr_addr_i == 2'd1 && !m_lock) m_mask <= wr_data_i[NEVT-1:0];
            if (wr_en_i && wr_addr_i == 2'd2) m_idle <= wr_data_i[NCH-1:0];
            m_flag <= f || (m_flag && !(wr_en_i && wr_addr_i == 2'd3 && wr_data_i[0]));
            m_hold <= f || (m_hold && !update_i);
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        bit a;
        logic [NCH-1:0] ep;
        a  = model_active();
        ep = a ? m_idle : pwm_i;
        check_bit(tag, "fault_active_o", fault_active_o, a);
        check_bit(tag, "fault_flag_o", fault_flag_o, m_flag);
        checks++;
        if (pwm_o !== ep) begin
            errors++;
            $display("FAIL %s pwm_o: actual=%h expected=%h", tag, pwm_o, ep);
        end
    endtask

    // One cycle: drive inputs after the falling edge, compare, then wait one clock.
    task automatic step(input string tag, input bit upd, input bit brk,
                        input bit [NEVT-1:0] evt, input bit wr = 0,
                        input bit [1:0] addr = 0, input bit [DW-1:0] data = 0);
        update_i = upd; brk_req_i = brk; evt_fault_i = evt;
        wr_en_i = wr; wr_addr_i = addr; wr_data_i = data;
        cyc++;
        pwm_i = NCH'(cyc * 29 + 3);
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input bit [1:0] addr, input bit [DW-1:0] data);
        step(tag, 0, 0, '0, 1, addr, data);
    endtask

    task automatic idle_n(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle_n("R1_reset", 3);
        rst_n = 1'b1;
        // R1: reset state, pass-through
        check_bit("R1", "flag after reset", fault_flag_o, 1'b0);
        idle_n("R1_passthrough", 3);
        // R5: disabled, faults have no effect
        step("R5_disabled", 0, 1, 4'hF);
        step("R5_disabled", 0, 1, 4'hF);
        wr("R10_cfg", 2'd2, 8'hA5);
        wr("R2_cfg", 2'd1, 8'h01);
        wr("R2_cfg", 2'd0, 8'h01);            // enable, cycle-by-cycle
        // R2: masked-in event gates outputs at once
        step("R2_event", 0, 0, 4'h1);
        step("R10_idle", 0, 0, 4'h1);
        // R6: hold until a fault-free update
        idle_n("R6_hold", 3);
        step("R6_update_during_fault", 1, 0, 4'h1);
        step("R6_release", 1, 0, 4'h0);
        idle_n("R6_resumed", 2);
        // R3: masked-off event
        step("R3_masked", 0, 0, 4'hE);
        step("R3_masked", 0, 0, 4'hE);
        // R8: clear during fault ignored, clear without fault works
        step("R8_clr_in_fault", 0, 0, 4'h1, 1, 2'd3, 8'h01);
        step("R8_still_set", 1, 0, 4'h0);
        wr("R8_clear", 2'd3, 8'h01);
        idle_n("R8_cleared", 2);
        wr("R8_write0", 2'd3, 8'h00);
        // R7: latched mode
        wr("R7_cfg", 2'd0, 8'h03);
        step("R7_fault", 0, 0, 4'h1);
        step("R7_update", 1, 0, 4'h0);
        idle_n("R7_hold", 3);
        step("R7_update2", 1, 0, 4'h0);
        wr("R7_clear", 2'd3, 8'h01);
        idle_n("R7_released", 2);
        // R4: break request as fault, then ignored
        wr("R4_cfg", 2'd0, 8'h01);
        step("R4_break", 0, 1, 4'h0);
        step("R4_break", 0, 1, 4'h0);
        step("R4_end", 1, 0, 4'h0);
        wr("R4_clr", 2'd3, 8'h01);
        wr("R4_ignore_cfg", 2'd0, 8'h05);
        step("R4_ignored", 0, 1, 4'h0);
        step("R4_ignored", 1, 1, 4'h0);
        // R10: different idle level
        wr("R10_cfg2", 2'd2, 8'h3C);
        step("R10_idle2", 0, 0, 4'h1);
        step("R10_idle2", 1, 0, 4'h0);
        wr("R10_clr", 2'd3, 8'h01);
        // R9: lock freezes the mask and cannot be cleared
        wr("R9_lock", 2'd0, 8'h09);
        wr("R9_mask_try", 2'd1, 8'h02);
        step("R9_old_mask", 0, 0, 4'h1);
        step("R9_old_mask_end", 1, 0, 4'h0);
        wr("R9_clr", 2'd3, 8'h01);
        step("R9_new_ignored", 0, 0, 4'h2);
        wr("R9_unlock_try", 2'd0, 8'h01);
        wr("R9_mask_try2", 2'd1, 8'h02);
        step("R9_still_locked", 0, 0, 4'h2);
        step("R9_still_old", 0, 0, 4'h1);
        step("R9_end", 1, 0, 4'h0);
        idle_n("R9_tail", 2);
        // R1: reset again clears everything
        rst_n = 1'b0;
        step("R1_rereset", 0, 0, 4'h0);
        rst_n = 1'b1;
        step("R1_after", 0, 0, 4'h1);
        step("R1_after", 0, 1, 4'h1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule